// File: doc/BRIEF.md
# Radix-2 Signed-Digit Carry-Free Adder

This block adds two numbers held in radix-2 signed-digit form. Each digit is worth -1, 0 or +1 and is carried on a pair of wires, a plus bit and a minus bit, whose difference is the digit's value. The adder forms every output digit from a small window of neighbouring input positions. No carry travels further than one position, so the depth of the sum logic stays the same at every word width. The result has one more digit than the operands, so the sum cannot overflow.

Two converters sit beside the adder. The input converter turns an unsigned binary word into signed-digit form. The output converter takes the signed-digit sum back to two's complement by subtracting the minus vector from the plus vector. The carry-propagating cost of the addition sits in this subtraction. The input converter, the digit adder and the output converter each have their own ports, so each can be driven and observed on its own. A parameter selects whether the results are registered on a valid strobe or pass straight through.

Top module: `bsd_adder_top`

## Requirements
- R1: The input converter drives `cvtPlus` equal to `binIn` and drives `cvtMinus` to all zeros.
- R2: Digit i of an operand has the value `plus[i] - minus[i]`. The codes 2'b00 and 2'b11 (plus, minus) are both accepted as zero, 2'b10 means +1 and 2'b01 means -1.
- R3: The signed-digit sum on `sumPlus`/`sumMinus` (DIGITS+1 digits, same encoding) has the value of operand A plus operand B for any operand digits.
- R4: No output digit uses the code 2'b11: `sumPlus & sumMinus` is zero.
- R5: Output digit i depends only on operand digits i, i-1 and i-2. Changing operand digit k leaves output digits below k unchanged.
- R6: `sumTwos` is the (DIGITS+2)-bit two's-complement value of the signed-digit sum.
- R7: A = 7 and B = 5, both produced by the input converter, give a sum whose value is 12 and `sumTwos` = ...0001100.
- R8: With REG_OUT=1, the results and `outValid` appear one clock after `inValid` is sampled high. `outValid` is high only in that cycle. The result outputs hold their value while `inValid` is low.
- R9: While `rstN` is low, `outValid`, `sumPlus`, `sumMinus` and `sumTwos` are all zero.
- R10: Operands with every digit +1 give 2*(2^DIGITS-1). Operands with every digit -1 give the negative of that value. Both appear correctly in `sumTwos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| binIn | input | DIGITS | Unsigned binary word for the input converter |
| cvtPlus | output | DIGITS | Plus bits of the converted word |
| cvtMinus | output | DIGITS | Minus bits of the converted word |
| inValid | input | 1 | Operands on A/B are valid this cycle |
| aPlus | input | DIGITS | Operand A plus bits |
| aMinus | input | DIGITS | Operand A minus bits |
| bPlus | input | DIGITS | Operand B plus bits |
| bMinus | input | DIGITS | Operand B minus bits |
| outValid | output | 1 | Results are valid this cycle |
| sumPlus | output | DIGITS+1 | Sum plus bits |
| sumMinus | output | DIGITS+1 | Sum minus bits |
| sumTwos | output | DIGITS+2 | Sum in two's complement |

## Verification
A faulty transfer or interim digit in one cell gives a sum value that is off by a power of two. The 11 code can also appear on an output digit. Both show up at the ports in the cycle after the operands are captured. A wrong choice of neighbour in the window can also shift the change into higher digits. The locality test catches a low digit that should have stayed the same, and the converter mismatch shows in `sumTwos` on the same vector. The bench decodes every result and compares it with the integer sum. Operand digits are drawn at random from all four codes, so both zero codes are covered.

// File: rtl/bsd_adder_pkg.sv
package bsd_adder_pkg;
  typedef struct packed {
    logic capture;
    logic outValid;
  } bsdStrobes_t;
endpackage

// File: rtl/bsd_digit_cell.sv
module bsd_digit_cell (
  input  logic aP,
  input  logic aM,
  input  logic bP,
  input  logic bM,
  input  logic lowNonNeg,
  output logic wP,
  output logic wM,
  output logic tP,
  output logic tM
);
  logic aPos, aNeg, aZero, bPos, bNeg, bZero;
  logic xPlus2, xPlus1, xMinus1, xMinus2;

  always_comb begin
    aPos  = aP & ~aM;
    aNeg  = aM & ~aP;
    aZero = ~(aPos | aNeg);
    bPos  = bP & ~bM;
    bNeg  = bM & ~bP;
    bZero = ~(bPos | bNeg);
    xPlus2  = aPos & bPos;
    xMinus2 = aNeg & bNeg;
    xPlus1  = (aPos & bZero) | (bPos & aZero);
    xMinus1 = (aNeg & bZero) | (bNeg & aZero);
    // transfer to next position
    tP = xPlus2 | (xPlus1 & lowNonNeg);
    tM = xMinus2 | (xMinus1 & ~lowNonNeg);
    // interim digit kept at this position
    wP = (xPlus1 | xMinus1) & ~lowNonNeg;
    wM = (xPlus1 | xMinus1) & lowNonNeg;
  end
endmodule

// File: rtl/bsd_adder_ctrl.sv
module bsd_adder_ctrl
  import bsd_adder_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output bsdStrobes_t strobes
);
  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign strobes.capture  = inValid & rstN;
      assign strobes.outValid = validQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk        = clk;
      assign strobes.capture  = inValid;
      assign strobes.outValid = inValid & rstN;
    end
  endgenerate
endmodule

// File: rtl/bsd_adder_dp.sv
module bsd_adder_dp
  import bsd_adder_pkg::*;
#(
  parameter int DIGITS  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsdStrobes_t       strobes,
  input  logic [DIGITS-1:0] aPlus,
  input  logic [DIGITS-1:0] aMinus,
  input  logic [DIGITS-1:0] bPlus,
  input  logic [DIGITS-1:0] bMinus,
  output logic [DIGITS:0]   sumPlus,
  output logic [DIGITS:0]   sumMinus,
  output logic [DIGITS+1:0] sumTwos
);
  localparam int SW = DIGITS + 1;
  localparam int TW = DIGITS + 2;

  logic [DIGITS-1:0] wP, wM;
  logic [DIGITS:0]   tP, tM;          // tP[i] enters position i
  logic [DIGITS-1:0] lowNonNeg;
  logic [SW-1:0]     sP, sM;
  logic [TW-1:0]     twosComb;

  assign tP[0] = 1'b0;
  assign tM[0] = 1'b0;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_cell
      if (i == 0) begin : g_lsb
        assign lowNonNeg[i] = 1'b1;
      end else begin : g_up
        assign lowNonNeg[i] = ~((aMinus[i-1] & ~aPlus[i-1]) |
                                (bMinus[i-1] & ~bPlus[i-1]));
      end
      bsd_digit_cell cell_i (
        .aP(aPlus[i]), .aM(aMinus[i]), .bP(bPlus[i]), .bM(bMinus[i]),
        .lowNonNeg(lowNonNeg[i]),
        .wP(wP[i]), .wM(wM[i]), .tP(tP[i+1]), .tM(tM[i+1])
      );
      assign sP[i] = (wP[i] & ~tM[i]) | (tP[i] & ~wM[i]);
      assign sM[i] = (wM[i] & ~tP[i]) | (tM[i] & ~wP[i]);
    end
  endgenerate

  assign sP[DIGITS] = tP[DIGITS];
  assign sM[DIGITS] = tM[DIGITS];

  // output converter: the only carry-propagating step
  assign twosComb = {1'b0, sP} - {1'b0, sM};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sumPlus  <= '0;
          sumMinus <= '0;
          sumTwos  <= '0;
        end else if (strobes.capture) begin
          sumPlus  <= sP;
          sumMinus <= sM;
          sumTwos  <= twosComb;
        end
      end
    end else begin : g_comb
      logic unusedIn;
      assign unusedIn = clk ^ strobes.capture ^ strobes.outValid;
      assign sumPlus  = rstN ? sP : '0;
      assign sumMinus = rstN ? sM : '0;
      assign sumTwos  = rstN ? twosComb : '0;
    end
  endgenerate
endmodule

// File: rtl/bsd_adder_top.sv
module bsd_adder_top
  import bsd_adder_pkg::*;
#(
  parameter int DIGITS  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIGITS-1:0] binIn,
  output logic [DIGITS-1:0] cvtPlus,
  output logic [DIGITS-1:0] cvtMinus,
  input  logic              inValid,
  input  logic [DIGITS-1:0] aPlus,
  input  logic [DIGITS-1:0] aMinus,
  input  logic [DIGITS-1:0] bPlus,
  input  logic [DIGITS-1:0] bMinus,
  output logic              outValid,
  output logic [DIGITS:0]   sumPlus,
  output logic [DIGITS:0]   sumMinus,
  output logic [DIGITS+1:0] sumTwos
);
  bsdStrobes_t strobes;

  // input converter: wiring only
  assign cvtPlus  = binIn;
  assign cvtMinus = '0;

  bsd_adder_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes)
  );

  bsd_adder_dp #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aPlus(aPlus), .aMinus(aMinus), .bPlus(bPlus), .bMinus(bMinus),
    .sumPlus(sumPlus), .sumMinus(sumMinus), .sumTwos(sumTwos)
  );

  assign outValid = strobes.outValid;
endmodule

// File: rtl/bsd_adder_chk.sv
module bsd_adder_chk #(
  parameter int DIGITS  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DIGITS-1:0] aPlus,
  input logic [DIGITS-1:0] aMinus,
  input logic [DIGITS-1:0] bPlus,
  input logic [DIGITS-1:0] bMinus,
  input logic              outValid,
  input logic [DIGITS:0]   sumPlus,
  input logic [DIGITS:0]   sumMinus,
  input logic [DIGITS+1:0] sumTwos
);
  function automatic longint opVal(input logic [DIGITS-1:0] p, input logic [DIGITS-1:0] m);
    return longint'(p) - longint'(m);
  endfunction

  function automatic longint sumVal(input logic [DIGITS:0] p, input logic [DIGITS:0] m);
    return longint'(p) - longint'(m);
  endfunction

  // R4: canonical output digits
  assert_canon_digit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sumPlus & sumMinus) == '0);

  // R6: converter agrees with the signed-digit sum
  assert_twos_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    longint'($signed(sumTwos)) == sumVal(sumPlus, sumMinus));

  generate
    if (REG_OUT) begin : g_reg
      // R8: valid one cycle after capture
      assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      assert_valid_only_R8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      // R8: hold while idle
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(sumPlus) && $stable(sumMinus) && $stable(sumTwos));
      // R3: sum value equals operand total
      assert_sum_value_R3: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> sumVal(sumPlus, sumMinus) ==
                    $past(opVal(aPlus, aMinus) + opVal(bPlus, bMinus)));
    end
  endgenerate
endmodule

bind bsd_adder_top bsd_adder_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .aPlus(aPlus), .aMinus(aMinus), .bPlus(bPlus), .bMinus(bMinus),
  .outValid(outValid), .sumPlus(sumPlus), .sumMinus(sumMinus), .sumTwos(sumTwos)
);

// File: tb/bsd_adder_tb_top.sv
`timescale 1ns/1ps
module bsd_adder_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] binIn = '0;
  logic [N-1:0] cvtPlus, cvtMinus;
  logic inValid = 1'b0;
  logic [N-1:0] aPlus = '0, aMinus = '0, bPlus = '0, bMinus = '0;
  logic outValid;
  logic [N:0] sumPlus, sumMinus;
  logic [N+1:0] sumTwos;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bsd_adder_top #(.DIGITS(N), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .binIn(binIn), .cvtPlus(cvtPlus), .cvtMinus(cvtMinus),
    .inValid(inValid), .aPlus(aPlus), .aMinus(aMinus), .bPlus(bPlus), .bMinus(bMinus),
    .outValid(outValid), .sumPlus(sumPlus), .sumMinus(sumMinus), .sumTwos(sumTwos)
  );

  function automatic longint opV(input logic [N-1:0] p, input logic [N-1:0] m);
    return longint'(p) - longint'(m);
  endfunction
  function automatic longint sumV(input logic [N:0] p, input logic [N:0] m);
    return longint'(p) - longint'(m);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [N-1:0] ap, am, bp, bm);
    @(negedge clk);
    aPlus = ap; aMinus = am; bPlus = bp; bMinus = bm;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkResult(input string tag);
    longint exp;
    exp = opV(aPlus, aMinus) + opV(bPlus, bMinus);
    check(outValid == 1'b1, {tag, " R8 valid"}, longint'(outValid), 1);
    check(sumV(sumPlus, sumMinus) == exp, {tag, " R3 value"}, sumV(sumPlus, sumMinus), exp);
    check((sumPlus & sumMinus) == '0, {tag, " R4 canon"}, longint'(sumPlus & sumMinus), 0);
    check(longint'($signed(sumTwos)) == exp, {tag, " R6 twos"}, longint'($signed(sumTwos)), exp);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    // R9 reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && sumPlus == '0 && sumMinus == '0 && sumTwos == '0,
          "R9 reset", longint'(sumTwos) + longint'(outValid), 0);
    rstN = 1'b1;

    // R1 input converter
    for (int k = 0; k < 4; k++) begin
      binIn = N'($urandom);
      #1;
      check(cvtPlus == binIn && cvtMinus == '0, "R1 convert",
            longint'(cvtPlus), longint'(binIn));
    end

    // R7: 7 + 5 through the converter
    binIn = N'(7); #1;
    aPlus = cvtPlus; aMinus = cvtMinus;
    binIn = N'(5); #1;
    runOp(aPlus, aMinus, cvtPlus, cvtMinus);
    check(sumV(sumPlus, sumMinus) == 12, "R7 value", sumV(sumPlus, sumMinus), 12);
    check(sumTwos == (N+2)'(12), "R7 binary 1100", longint'(sumTwos), 12);

    // R8 hold: change operands with inValid low
    @(negedge clk);
    begin
      logic [N+1:0] held;
      held = sumTwos;
      aPlus = '1; bPlus = '1; aMinus = '0; bMinus = '0;
      @(negedge clk);
      check(outValid == 1'b0, "R8 idle valid", longint'(outValid), 0);
      check(sumTwos == held, "R8 hold", longint'(sumTwos), longint'(held));
    end

    // R10 extremes
    runOp('1, '0, '1, '0);
    checkResult("R10 max");
    check(longint'($signed(sumTwos)) == 2 * ((1 << N) - 1), "R10 max",
          longint'($signed(sumTwos)), 2 * ((1 << N) - 1));
    runOp('0, '1, '0, '1);
    checkResult("R10 min");
    check(longint'($signed(sumTwos)) == -2 * ((1 << N) - 1), "R10 min",
          longint'($signed(sumTwos)), -2 * ((1 << N) - 1));

    // R2: both zero codes give zero
    runOp('1, '1, '0, '0);
    check(sumV(sumPlus, sumMinus) == 0, "R2 zero codes", sumV(sumPlus, sumMinus), 0);

    // R3/R2 random digits, all four codes
    for (int v = 0; v < 300; v++) begin
      runOp(N'($urandom), N'($urandom), N'($urandom), N'($urandom));
      checkResult("R2 R3 random");
    end

    // R5 locality
    for (int v = 0; v < 40; v++) begin
      logic [N:0] refP, refM;
      logic [N-1:0] ap, am, bp, bm;
      int k;
      ap = N'($urandom); am = N'($urandom); bp = N'($urandom); bm = N'($urandom);
      k = 1 + int'($urandom % (N - 1));
      runOp(ap, am, bp, bm);
      refP = sumPlus; refM = sumMinus;
      ap[k] = ~ap[k];
      runOp(ap, am, bp, bm);
      for (int i = 0; i < k; i++) begin
        check(sumPlus[i] == refP[i] && sumMinus[i] == refM[i], "R5 locality",
              longint'({sumPlus[i], sumMinus[i]}), longint'({refP[i], refM[i]}));
      end
      checkResult("R5 after change");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule